// File: doc/BRIEF.md
# Reprogrammable Byte Memory Bus-Mode Model

This block is a synthesizable, clocked behavioural front end for a byte-wide reprogrammable read-only memory. Each cycle it samples the control pins: active-low chip enable and output enable, a flag for the programming supply at high voltage, a flag for the identifier high voltage on address line 9, and a flag for a supply below the write threshold. From these it picks one bus mode. It then reads the small internal cell array, returns one of two identifier bytes, programs a byte, or floats the data outputs.

Analog levels are single-bit flags, and no access-time delays are modelled. The read path has one output register, so every result appears on `dout`/`dout_oe` at the first rising edge after the inputs are applied. Programming can only clear bits. A bulk erase strobe, taken only while the programming supply is high, sets every cell back to all ones. A supply lockout blocks every write and has to re-arm after the supply recovers.

Top module: `eprom_bus_model`

## Requirements
- R1: With vpp_hi=0, ce_n=0, oe_n=0 and a9_hv=0, the edge after the inputs makes dout_oe=1 and dout equal to the stored byte at addr.
- R2: With vpp_hi=0, the edge after ce_n=1 (standby), or after ce_n=0 with oe_n=1 (output disable), makes dout_oe=0 and dout=8'h00, whatever a9_hv, addr and din are.
- R3: With vpp_hi=0, ce_n=0, oe_n=0 and a9_hv=1, dout_oe=1 and dout is 8'hC2 when addr bit 0 is 0 and 8'hC0 when it is 1. All other address bits are ignored.
- R4: With vpp_hi=1, ce_n=0 and oe_n=1, the byte at addr becomes (old & din) at that edge when writes are allowed, and the outputs float (dout_oe=0).
- R5: With vpp_hi=1 and oe_n=0 (ce_n=1 verify, or ce_n=0), the outputs drive the stored byte at addr.
- R6: With vpp_hi=1, ce_n=1 and oe_n=1, nothing is written and the outputs float.
- R7: While vpp_hi=0, no combination of controls, din or erase_stb changes any stored byte.
- R8: While low_vcc=1, neither programming nor erase takes effect. The first edge at which low_vcc is seen low only re-arms writing, so writes are accepted from the next edge on. Reset also leaves writing disarmed until the first edge after it.
- R9: Reset sets every stored byte to 8'hFF and drives dout_oe=0, dout=8'h00.
- R10: erase_stb=1 with vpp_hi=1 and writes allowed sets every byte to 8'hFF at that edge, and it takes priority over a program in the same cycle.
- R11: When vpp_hi=1, a9_hv has no effect: reads return array data, not identifier bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply at high voltage |
| a9_hv | input | 1 | Identifier high voltage present on address line 9 |
| low_vcc | input | 1 | Supply below write threshold |
| erase_stb | input | 1 | Bulk erase request |
| addr | input | AW | Byte address; bit 0 also selects the identifier byte |
| din | input | 8 | Program data |
| dout | output | 8 | Registered read data, 8'h00 while floating |
| dout_oe | output | 1 | Output driver enable |

## Verification
The hardest situation to reach is the re-arm window of the supply lockout. It needs a program attempt in the one cycle after low_vcc falls, a cycle in which every other condition for a write holds. The stimulus asserts low_vcc across a program and an erase attempt, drops it while keeping the program pins held, and then reads back in verify mode to show that only the later attempt changed the byte. A sweep over all 64 combinations of the control flags and two address bits, with bit-clearing data, then confirms that no mode other than a programming mode at high supply disturbs the array.

// File: rtl/eprom_mode_pkg.sv
package eprom_mode_pkg;

  typedef enum logic [2:0] {
    MD_READ    = 3'd0,
    MD_IDENT   = 3'd1,
    MD_ODIS    = 3'd2,
    MD_STBY    = 3'd3,
    MD_PROG    = 3'd4,
    MD_VERIFY  = 3'd5,
    MD_INHIBIT = 3'd6
  } bus_mode_e;

  // identifier byte chosen by address bit 0
  function automatic logic [7:0] ident_code(input logic sel,
                                            input logic [7:0] mfr,
                                            input logic [7:0] dev);
    return sel ? dev : mfr;
  endfunction

  // programming can only clear bits
  function automatic logic [7:0] program_merge(input logic [7:0] old_b,
                                               input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic mode_drives(input bus_mode_e m);
    return (m == MD_READ) || (m == MD_IDENT) || (m == MD_VERIFY);
  endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_mode_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      vpp_hi,
  input  logic      a9_hv,
  output bus_mode_e mode,
  output logic      prog_req
);

  always_comb begin
    if (!vpp_hi) begin
      if (ce_n)       mode = MD_STBY;
      else if (oe_n)  mode = MD_ODIS;
      else if (a9_hv) mode = MD_IDENT;
      else            mode = MD_READ;
    end else begin
      unique case ({ce_n, oe_n})
        2'b11:   mode = MD_INHIBIT;
        2'b01:   mode = MD_PROG;
        2'b10:   mode = MD_VERIFY;
        default: mode = MD_READ;
      endcase
    end
  end

  assign prog_req = (mode == MD_PROG);

endmodule

// File: rtl/eprom_write_gate.sv
module eprom_write_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic low_vcc,
  input  logic vpp_hi,
  input  logic prog_req,
  input  logic erase_stb,
  output logic wr_en,
  output logic er_en
);

  logic armed;
  logic write_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= !low_vcc;
  end

  assign write_ok = vpp_hi && armed && !low_vcc;
  assign er_en    = write_ok && erase_stb;
  assign wr_en    = write_ok && prog_req && !er_en;

  // R8
  lockout_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_vcc |-> (!wr_en && !er_en));
  // R8
  rearm_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low_vcc) |-> (!wr_en && !er_en));
  // R7
  vpp_low_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_hi |-> (!wr_en && !er_en));
  // R10
  erase_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_en |-> !wr_en);

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
  import eprom_mode_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          er_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rd_data
);

  localparam int NW = 1 << AW;
  localparam logic [DW-1:0] BLANK = '1;

  logic [DW-1:0] mem [NW];

  always_ff @(posedge clk) begin
    if (!rst_n || er_en) begin
      for (int i = 0; i < NW; i++) mem[i] <= BLANK;
    end else if (wr_en) begin
      mem[addr] <= program_merge(mem[addr], din);
    end
  end

  assign rd_data = mem[addr];

  // check registers for the assertions
  logic          chk_wr;
  logic          chk_er;
  logic [AW-1:0] chk_addr;
  logic [DW-1:0] chk_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_wr   <= 1'b0;
      chk_er   <= 1'b0;
      chk_addr <= '0;
      chk_val  <= '0;
    end else begin
      chk_wr   <= wr_en && !er_en;
      chk_er   <= er_en;
      chk_addr <= addr;
      chk_val  <= rd_data & din;
    end
  end

  // R4
  program_clears_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_wr |-> (mem[chk_addr] == chk_val));
  // R10
  erase_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_er |-> (mem[0] == BLANK && mem[NW-1] == BLANK));

endmodule

// File: rtl/eprom_bus_out.sv
module eprom_bus_out
  import eprom_mode_pkg::*;
#(
  parameter logic [7:0] MFR_ID = 8'hC2,
  parameter logic [7:0] DEV_ID = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  bus_mode_e  mode,
  input  logic       a0,
  input  logic [7:0] arr_data,
  output logic [7:0] dout,
  output logic       dout_oe
);

  logic [7:0] next_data;
  logic       next_oe;

  always_comb begin
    next_oe = mode_drives(mode);
    if (!next_oe)               next_data = 8'h00;
    else if (mode == MD_IDENT)  next_data = ident_code(a0, MFR_ID, DEV_ID);
    else                        next_data = arr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= 8'h00;
      dout_oe <= 1'b0;
    end else begin
      dout    <= next_data;
      dout_oe <= next_oe;
    end
  end

  // R2
  float_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STBY || mode == MD_ODIS || mode == MD_PROG || mode == MD_INHIBIT)
    |=> (!dout_oe && dout == 8'h00));
  // R3
  ident_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_IDENT && !a0) |=> (dout_oe && dout == MFR_ID));
  // R3
  ident_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_IDENT && a0) |=> (dout_oe && dout == DEV_ID));
  // R5
  verify_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_VERIFY) |=> (dout_oe && dout == $past(arr_data)));

endmodule

// File: rtl/eprom_bus_model.sv
module eprom_bus_model
  import eprom_mode_pkg::*;
#(
  parameter int         AW     = 4,
  parameter logic [7:0] MFR_ID = 8'hC2,
  parameter logic [7:0] DEV_ID = 8'hC0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          vpp_hi,
  input  logic          a9_hv,
  input  logic          low_vcc,
  input  logic          erase_stb,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_oe
);

  bus_mode_e  mode;
  logic       prog_req;
  logic       wr_en;
  logic       er_en;
  logic [7:0] arr_data;

  eprom_mode_decode u_dec (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_hi  (vpp_hi),
    .a9_hv   (a9_hv),
    .mode    (mode),
    .prog_req(prog_req)
  );

  eprom_write_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .low_vcc  (low_vcc),
    .vpp_hi   (vpp_hi),
    .prog_req (prog_req),
    .erase_stb(erase_stb),
    .wr_en    (wr_en),
    .er_en    (er_en)
  );

  eprom_cell_array #(.AW(AW), .DW(8)) u_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .er_en  (er_en),
    .addr   (addr),
    .din    (din),
    .rd_data(arr_data)
  );

  eprom_bus_out #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .a0      (addr[0]),
    .arr_data(arr_data),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

  // R11
  a9_ignored_at_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && !oe_n) |=> (dout_oe && dout == $past(arr_data)));

endmodule

// File: tb/sim_eprom_bus_model.sv
module sim_eprom_bus_model;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0;
  logic       low_vcc = 1'b0, erase_stb = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] ref_mem [16];
  logic armed_ref = 1'b0;

  always #2 clk = ~clk;

  eprom_bus_model #(.AW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .low_vcc(low_vcc), .erase_stb(erase_stb), .addr(addr),
    .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
               tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // one bus cycle: drive at falling edge, sample just after the rising edge
  task automatic cyc(input logic ce, input logic oe, input logic vpp, input logic a9,
                     input logic lv, input logic er, input logic [3:0] ad,
                     input logic [7:0] d, input string tag);
    logic drv, idm, prg, ok;
    string t;
    @(negedge clk);
    ce_n = ce; oe_n = oe; vpp_hi = vpp; a9_hv = a9; low_vcc = lv;
    erase_stb = er; addr = ad; din = d;
    @(posedge clk); #1;
    idm = 1'b0; prg = 1'b0;
    if (!vpp) begin
      drv = !ce && !oe;
      idm = drv && a9;
      t = !drv ? "R2" : (idm ? "R3" : "R1");
    end else begin
      drv = !oe;
      prg = !ce && oe;
      t = drv ? "R5" : (prg ? "R4" : "R6");
    end
    if (tag != "") t = tag;
    check({dout_oe, dout},
          {drv, !drv ? 8'h00 : (idm ? (ad[0] ? 8'hC0 : 8'hC2) : ref_mem[ad])}, t);
    ok = vpp && !lv && armed_ref;
    if (ok && er) begin
      for (int i = 0; i < 16; i++) ref_mem[i] = 8'hFF;
    end else if (ok && prg) begin
      ref_mem[ad] = ref_mem[ad] & d;
    end
    armed_ref = !lv;
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 16; a++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'(a), 8'h00, tag);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    check({dout_oe, dout}, 9'h000, "R9");
    @(negedge clk); rst_n = 1'b1;
    // R9: blank after reset
    read_all("R9");
    // R4: program a pattern, R5 verify, R1 read at low supply
    for (int a = 0; a < 16; a++)
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'(a), 8'((a * 29) ^ 8'hA5), "R4");
    for (int a = 0; a < 16; a++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'(a), 8'h00, "R5");
    read_all("R1");
    // R4: second program clears only more bits
    for (int a = 0; a < 16; a++)
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'(a), 8'hF7 ^ 8'(a << 4), "R4");
    for (int a = 0; a < 16; a++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'(a), 8'h00, "R4");
    // R3: identifier bytes, upper address bits ignored
    for (int a = 0; a < 16; a++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'(a), 8'h00, "R3");
    // R11: identifier flag ignored at high supply
    for (int a = 0; a < 4; a++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'(a), 8'h00, "R11");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd9, 8'h00, "R11");
    // exhaustive control sweep; tag derived from mode (R2, R6 among them)
    for (int k = 0; k < 64; k++)
      cyc(k[0], k[1], k[2], k[3], 1'b0, 1'b0,
          {k[5], k[5] ^ k[4], 1'b1, k[4]}, ~(8'h01 << (k % 8)), "");
    // R7: supply low never writes, even with erase strobe
    for (int a = 0; a < 8; a++)
      cyc(a[0], a[1], 1'b0, a[2], 1'b0, 1'b1, 4'(a), 8'h00, "R7");
    read_all("R7");
    // R8: lockout and re-arm delay
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5, 8'h00, "R8");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5, 8'h00, "R8");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5, 8'h00, "R8");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5, 8'h00, "R8");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5, 8'h0F, "R8");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5, 8'h00, "R8");
    read_all("R8");
    // R6: inhibit never writes
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6, 8'h00, "R6");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6, 8'h00, "R6");
    // R10: erase wins over a program in the same cycle
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 8'h00, "R10");
    read_all("R10");
    summary();
  end

endmodule